// File: doc/BRIEF.md
# Event-Triggered Sample History Buffer

This block keeps a rolling record of an 8-bit biosignal sample stream. Each one-cycle sample strobe writes one byte into a circular memory. At 256 samples per second, the default depth of 2048 entries holds the latest 8 seconds of signal. Older data is overwritten as the write position wraps from the top of the memory back to the bottom.

A detector somewhere else in the chip raises an event line. That line may be asynchronous to this clock. The block synchronizes it and freezes recording on its rising edge. It then sends the stored history out, oldest byte first, over a valid/ready byte port to a packetizer or radio. Transmission is off at all other times. The last byte of a dump is flagged, and a completion pulse follows it. Recording then starts again from an empty memory.

Two kinds of input are not acted on while a dump is in progress. Samples that arrive are discarded and counted, and further events are ignored.

Top module: `event_history_buffer`

## Requirements
- R1: While recording, each strobe stores `smp_data` at the write position, which then advances by one and wraps from DEPTH-1 to 0. Once the ring has wrapped, the newest DEPTH samples are kept and older ones are overwritten.
- R2: After the ring has wrapped, an event dumps exactly DEPTH bytes, starting with the oldest sample still held and ending with the newest.
- R3: Before the ring has wrapped, an event dumps only the N samples written so far, in the order they were written.
- R4: A byte moves only on a clock edge where `out_valid` and `out_ready` are both 1. While `out_valid` is 1 and `out_ready` is 0, `out_valid`, `out_data` and `out_last` hold their values.
- R5: `out_last` is 1 together with the final byte of a dump and 0 with every other byte. `dump_done` is a one-cycle pulse in the cycle after that final byte transfers.
- R6: After `dump_done`, recording restarts from an empty memory, so the next dump holds only the samples taken after it.
- R7: Strobes that arrive while `dump_active` is 1 are not stored. Each one adds one to `drop_count`, which saturates at its maximum and is cleared only by reset.
- R8: Events that arrive while `dump_active` is 1 are ignored. The dump in progress is unchanged, and no second dump follows it.
- R9: An event that arrives while the memory is empty produces no output and leaves recording running.
- R10: `evt_async` passes through a two-stage synchronizer, and only its rising edge starts a dump. A level held high across the end of a dump does not start another one.
- R11: Reset (`rst` = 1, synchronous, active high) clears `out_valid`, `out_last`, `dump_done`, `dump_active` and `drop_count`, and empties the memory.
- R12: `out_valid` stays 0 whenever no dump is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_stb | input | 1 | One-cycle sample strobe |
| smp_data | input | DATA_W | Sample byte |
| evt_async | input | 1 | Detection event, may be asynchronous; rising edge triggers |
| out_ready | input | 1 | Downstream ready |
| out_valid | output | 1 | Output byte valid |
| out_data | output | DATA_W | Output byte |
| out_last | output | 1 | Marks the final byte of a dump |
| dump_done | output | 1 | One-cycle pulse after the final byte transfers |
| dump_active | output | 1 | High from event acceptance until the dump completes |
| drop_count | output | DROP_W | Saturating count of discarded strobes |

## Verification
The bench runs several fill levels back to back, without a reset between them:
- A single sample.
- A partly filled ring.
- A ring filled to exactly its depth.
- A ring wrapped once and a ring wrapped twice.

Together these separate a start at address 0 from a start at the write position. They also show whether the byte count follows the fill level or the depth, and whether each dump restarts empty.

Each fill level is read out under a different ready pattern: always ready, alternating, and sparse. These patterns separate correct stall holding from lost or repeated bytes.

Directed cases cover the following:
- Strobes and repeat events injected during a dump.
- An event line held high across the end of a dump.
- An event on an empty memory.
- Reset clearing the drop count.

// File: rtl/hb_pkg.sv
package hb_pkg;

  typedef enum logic [1:0] {
    ST_CAP   = 2'd0,
    ST_RD    = 2'd1,
    ST_LOAD  = 2'd2,
    ST_SERVE = 2'd3
  } hb_state_e;

endpackage

// File: rtl/hb_evt_sync.sv
module hb_evt_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic evt_async,
  output logic evt_rise
);

  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) sync_q[g] <= 1'b0;
          else     sync_q[g] <= evt_async;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) sync_q[g] <= 1'b0;
          else     sync_q[g] <= sync_q[g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= sync_q[STAGES-1];
  end

  assign evt_rise = sync_q[STAGES-1] & ~prev_q;

endmodule

// File: rtl/hb_ring_mem.sv
module hb_ring_mem #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 2048,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [AW-1:0]     rd_addr,
  output logic [DATA_W-1:0] rd_q
);

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
    rd_q <= mem[rd_addr];
  end

endmodule

// File: rtl/hb_ctrl.sv
module hb_ctrl
  import hb_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 2048,
  parameter int DROP_W = 16,
  localparam int AW    = $clog2(DEPTH),
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              smp_stb,
  input  logic              evt_rise,
  input  logic              out_ready,
  input  logic [DATA_W-1:0] rd_q,
  output logic              wr_en,
  output logic [AW-1:0]     wr_addr,
  output logic [AW-1:0]     rd_addr,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  output logic              out_last,
  output logic              dump_done,
  output logic              dump_active,
  output logic [DROP_W-1:0] drop_count
);

  localparam logic [AW-1:0] TOP_ADDR = AW'(DEPTH - 1);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

  hb_state_e     state;
  logic [AW-1:0] wr_ptr;
  logic [AW-1:0] rd_ptr;
  logic          wrapped;
  logic [CW-1:0] remain;

  logic          at_top;
  logic [AW-1:0] ptr_nxt;
  logic          wrap_nxt;
  logic          have_data;
  logic [AW-1:0] start_addr;
  logic [CW-1:0] fill_cnt;

  always_comb begin
    at_top     = (wr_ptr == TOP_ADDR);
    wr_en      = smp_stb && (state == ST_CAP);
    ptr_nxt    = wr_ptr;
    wrap_nxt   = wrapped;
    if (wr_en) begin
      ptr_nxt  = at_top ? '0 : wr_ptr + 1'b1;
      wrap_nxt = wrapped | at_top;
    end
    have_data  = wrap_nxt || (ptr_nxt != '0);
    start_addr = wrap_nxt ? ptr_nxt : '0;
    fill_cnt   = wrap_nxt ? FULL_CNT : CW'(ptr_nxt);
  end

  assign wr_addr     = wr_ptr;
  assign rd_addr     = rd_ptr;
  assign dump_active = (state != ST_CAP);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_CAP;
      wr_ptr    <= '0;
      wrapped   <= 1'b0;
      rd_ptr    <= '0;
      remain    <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
      out_last  <= 1'b0;
      dump_done <= 1'b0;
    end else begin
      dump_done <= 1'b0;
      case (state)
        ST_CAP: begin
          wr_ptr  <= ptr_nxt;
          wrapped <= wrap_nxt;
          if (evt_rise && have_data) begin
            rd_ptr <= start_addr;
            remain <= fill_cnt;
            state  <= ST_RD;
          end
        end
        ST_RD: begin
          state <= ST_LOAD;
        end
        ST_LOAD: begin
          out_data  <= rd_q;
          out_valid <= 1'b1;
          out_last  <= (remain == CW'(1));
          state     <= ST_SERVE;
        end
        ST_SERVE: begin
          if (out_ready) begin
            out_valid <= 1'b0;
            out_last  <= 1'b0;
            if (remain == CW'(1)) begin
              dump_done <= 1'b1;
              wr_ptr    <= '0;
              wrapped   <= 1'b0;
              remain    <= '0;
              state     <= ST_CAP;
            end else begin
              rd_ptr <= (rd_ptr == TOP_ADDR) ? '0 : rd_ptr + 1'b1;
              remain <= remain - 1'b1;
              state  <= ST_RD;
            end
          end
        end
        default: state <= ST_CAP;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      drop_count <= '0;
    end else if ((state != ST_CAP) && smp_stb && !(&drop_count)) begin
      drop_count <= drop_count + 1'b1;
    end
  end

  AST_HOLD_WHILE_STALLED: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last))); // R4

  AST_DONE_FOLLOWS_LAST: assert property (@(posedge clk) disable iff (rst)
    dump_done |-> $past(out_valid && out_ready && out_last)); // R5

  AST_RESTART_EMPTY: assert property (@(posedge clk) disable iff (rst)
    dump_done |-> ((wr_ptr == '0) && !wrapped && (state == ST_CAP))); // R6

  AST_NO_VALID_IN_CAPTURE: assert property (@(posedge clk) disable iff (rst)
    (state == ST_CAP) |-> !out_valid); // R12

  AST_DROP_COUNTS: assert property (@(posedge clk) disable iff (rst)
    ((state != ST_CAP) && smp_stb && !(&drop_count)) |=>
      (drop_count == DROP_W'($past(drop_count) + 1'b1))); // R7

  AST_PTR_FROZEN: assert property (@(posedge clk) disable iff (rst)
    ((state == ST_RD) || (state == ST_LOAD)) |=> $stable(wr_ptr)); // R7

  AST_EVT_IGNORED_IN_DUMP: assert property (@(posedge clk) disable iff (rst)
    ((state == ST_LOAD) && evt_rise) |=> ((state == ST_SERVE) && $stable(rd_ptr))); // R8

endmodule

// File: rtl/event_history_buffer.sv
module event_history_buffer #(
  parameter int DATA_W      = 8,
  parameter int DEPTH       = 2048,
  parameter int DROP_W      = 16,
  parameter int SYNC_STAGES = 2,
  localparam int AW         = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              smp_stb,
  input  logic [DATA_W-1:0] smp_data,
  input  logic              evt_async,
  input  logic              out_ready,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  output logic              out_last,
  output logic              dump_done,
  output logic              dump_active,
  output logic [DROP_W-1:0] drop_count
);

  logic              evt_rise;
  logic              wr_en;
  logic [AW-1:0]     wr_addr;
  logic [AW-1:0]     rd_addr;
  logic [DATA_W-1:0] rd_q;

  hb_evt_sync #(
    .STAGES(SYNC_STAGES)
  ) i_sync (
    .clk      (clk),
    .rst      (rst),
    .evt_async(evt_async),
    .evt_rise (evt_rise)
  );

  hb_ring_mem #(
    .DATA_W(DATA_W),
    .DEPTH (DEPTH)
  ) i_mem (
    .clk    (clk),
    .wr_en  (wr_en),
    .wr_addr(wr_addr),
    .wr_data(smp_data),
    .rd_addr(rd_addr),
    .rd_q   (rd_q)
  );

  hb_ctrl #(
    .DATA_W(DATA_W),
    .DEPTH (DEPTH),
    .DROP_W(DROP_W)
  ) i_ctrl (
    .clk        (clk),
    .rst        (rst),
    .smp_stb    (smp_stb),
    .evt_rise   (evt_rise),
    .out_ready  (out_ready),
    .rd_q       (rd_q),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .rd_addr    (rd_addr),
    .out_valid  (out_valid),
    .out_data   (out_data),
    .out_last   (out_last),
    .dump_done  (dump_done),
    .dump_active(dump_active),
    .drop_count (drop_count)
  );

endmodule

// File: tb/test_event_history_buffer.sv
`timescale 1ns/1ps
module test_event_history_buffer;

  localparam int D  = 16;
  localparam int DW = 8;
  localparam int PW = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          smp_stb = 1'b0;
  logic [DW-1:0] smp_data = '0;
  logic          evt_async = 1'b0;
  logic          out_ready = 1'b0;
  logic          out_valid;
  logic [DW-1:0] out_data;
  logic          out_last;
  logic          dump_done;
  logic          dump_active;
  logic [PW-1:0] drop_count;

  int n_chk  = 0;
  int n_fail = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  event_history_buffer #(
    .DATA_W(DW), .DEPTH(D), .DROP_W(PW), .SYNC_STAGES(2)
  ) i_event_history_buffer (
    .clk(clk), .rst(rst), .smp_stb(smp_stb), .smp_data(smp_data),
    .evt_async(evt_async), .out_ready(out_ready), .out_valid(out_valid),
    .out_data(out_data), .out_last(out_last), .dump_done(dump_done),
    .dump_active(dump_active), .drop_count(drop_count)
  );

  // {samples written, first sample value, ready pattern mask}
  localparam logic [23:0] VEC [6] = '{
    {8'd5,  8'h10, 8'hFF},
    {8'd16, 8'h40, 8'h55},
    {8'd23, 8'h80, 8'h49},
    {8'd40, 8'hC0, 8'hFF},
    {8'd1,  8'h01, 8'hAA},
    {8'd15, 8'h70, 8'hFF}
  };

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic put_sample(input logic [DW-1:0] v);
    @(negedge clk);
    smp_stb  = 1'b1;
    smp_data = v;
    @(negedge clk);
    smp_stb  = 1'b0;
  endtask

  task automatic pulse_evt();
    @(negedge clk);
    evt_async = 1'b1;
    repeat (3) @(negedge clk);
    evt_async = 1'b0;
  endtask

  function automatic logic [DW-1:0] exp_byte(input int n, input logic [DW-1:0] seed,
                                             input int i);
    if (n <= D) return DW'(seed + i);
    return DW'(seed + (n - D) + i);
  endfunction

  // Reads one dump and compares it against the expected bytes.
  task automatic collect(input int n, input logic [DW-1:0] seed,
                         input logic [7:0] mask, input string req);
    int   n_exp = (n < D) ? n : D;
    int   got = 0;
    int   cyc = 0;
    bit   hold = 0;
    bit   exp_done = 0;
    bit   seen_done = 0;
    logic [DW-1:0] held = '0;
    while (!seen_done && cyc < 4000) begin
      @(negedge clk);
      cyc++;
      if (exp_done) begin
        chk(dump_done == 1'b1, "R5", "done pulse after last byte", dump_done, 1);
        seen_done = 1;
      end else if (dump_done) begin
        chk(0, "R5", "early done pulse, byte count", got, n_exp);
        seen_done = 1;
      end
      if (hold) begin
        chk(out_valid && out_data == held, "R4", "stalled byte held", out_data, held);
      end
      out_ready = mask[cyc % 8];
      if (out_valid && out_ready) begin
        chk(out_data == exp_byte(n, seed, got), req, "byte value in order",
            out_data, exp_byte(n, seed, got));
        chk(out_last == (got == n_exp - 1), "R5", "last flag", out_last,
            int'(got == n_exp - 1));
        if (got == n_exp - 1) exp_done = 1;
        got++;
        hold = 0;
      end else begin
        hold = out_valid;
        held = out_data;
      end
    end
    out_ready = 1'b0;
    chk(got == n_exp, req, "bytes in dump", got, n_exp);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog run hung actual=%0d expected=%0d", 1, 0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin : main
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11: reset state
    chk(out_valid == 0, "R11", "out_valid after reset", out_valid, 0);
    chk(dump_active == 0, "R11", "dump_active after reset", dump_active, 0);
    chk(dump_done == 0, "R11", "dump_done after reset", dump_done, 0);
    chk(drop_count == 0, "R11", "drop_count after reset", drop_count, 0);

    // R9: event on empty memory gives nothing; recording continues
    pulse_evt();
    repeat (12) @(negedge clk);
    chk(dump_active == 0, "R9", "no dump on empty memory", dump_active, 0);
    chk(out_valid == 0, "R9", "no output on empty memory", out_valid, 0);
    for (int i = 0; i < 3; i++) put_sample(DW'(8'hE0 + i));
    pulse_evt();
    collect(3, 8'hE0, 8'hFF, "R9");

    // Table of fill levels and ready patterns; no reset between rows (R6)
    for (int v = 0; v < 6; v++) begin
      int            n    = int'(VEC[v][23:16]);
      logic [DW-1:0] seed = VEC[v][15:8];
      logic [7:0]    mask = VEC[v][7:0];
      for (int i = 0; i < n; i++) put_sample(DW'(seed + i));
      repeat (2) @(negedge clk);
      chk(out_valid == 0, "R12", "no output while recording", out_valid, 0);
      pulse_evt();
      collect(n, seed, mask, (n > D) ? "R1_R2_R6" : (n == D) ? "R1" : "R3_R6");
    end

    // R7 and R8: strobes and events during a dump
    for (int i = 0; i < 6; i++) put_sample(DW'(8'h20 + i));
    pulse_evt();
    while (!out_valid) @(negedge clk);
    begin
      int d0 = int'(drop_count);
      for (int i = 0; i < 3; i++) put_sample(8'hFF);
      pulse_evt();
      @(negedge clk);
      chk(int'(drop_count) == d0 + 3, "R7", "drop counter", drop_count, d0 + 3);
    end
    collect(6, 8'h20, 8'hFF, "R7_R8");
    repeat (12) @(negedge clk);
    chk(dump_active == 0, "R8", "no second dump", dump_active, 0);
    chk(out_valid == 0, "R8", "no output after ignored event", out_valid, 0);

    // R10: level held high across the end of a dump does not retrigger
    for (int i = 0; i < 4; i++) put_sample(DW'(8'h33 + i));
    @(negedge clk);
    evt_async = 1'b1;
    collect(4, 8'h33, 8'hFF, "R10");
    for (int i = 0; i < 2; i++) put_sample(DW'(8'h50 + i));
    repeat (12) @(negedge clk);
    chk(dump_active == 0, "R10", "held level no retrigger", dump_active, 0);
    evt_async = 1'b0;
    repeat (4) @(negedge clk);
    pulse_evt();
    collect(2, 8'h50, 8'hFF, "R10");

    // R11: reset clears the drop count
    chk(drop_count != 0, "R7", "drop counter kept", drop_count, 3);
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(drop_count == 0, "R11", "drop_count cleared by reset", drop_count, 0);

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule